// File: doc/BRIEF.md
# Video Status and Interrupt Controller

This block collects the event conditions raised by a video display controller and turns them into a sticky status byte and one active-high interrupt request for the host CPU. It tracks six events: sprite collision, sprite overflow (more than 16 sprites landing on one line), a scanline match, completion of a sprite-table DMA, completion of a memory-to-memory DMA, and vertical blanking. Each event arrives as a single-cycle pulse. It is latched into its own flag whether or not its interrupt is enabled, so software can also find events by polling.

The interrupt enables come from two programmable registers. A display-control word enables collision, overflow, scanline and vertical-blank interrupts. A DMA-control word enables the two DMA completion interrupts. A third register holds the target line for the scanline event. The block compares it against the incoming visible-line counter, and the first visible line is numbered 64. One read strobe returns all the flags and clears them in the same access.

Top module: `vstat_irq_ctrl`

## Requirements
- R1: After reset, `stat_o` is 0, `irq_o` is 0, all enables are 0 and the raster target is 0.
- R2: A pulse on `ev_i[k]` sets `stat_o[k]` on the next clock edge. The bit positions are: 0 collision, 1 overflow, 3 sprite-table DMA end, 4 memory-to-memory DMA end, 5 vertical blank.
- R3: A flag is set by its event even when its interrupt enable is 0.
- R4: `irq_o` is the OR over k of `stat_o[k]` AND the enable of bit k. A write with `wr_sel_i`=0 loads data bits 3:0 as the enables of status bits 0, 1, 2 and 5. A write with `wr_sel_i`=1 loads data bit 0 as the enable of status bit 3 and data bit 1 as the enable of status bit 4.
- R5: In a cycle with `rd_stat_i` high, `stat_o` shows the current flags. After that edge, every flag without a new event is 0 and `irq_o` falls.
- R6: An event that arrives in the same cycle as a read leaves its flag set after the read.
- R7: A write with `wr_sel_i`=2 loads data bits 9:0 as the raster target. `stat_o[2]` sets one edge after `line_i`+64 first becomes equal to the target. It does not set again while the equality merely holds.
- R8: Flags persist until read. Changing the enables alters `irq_o` but never the flags.
- R9: The line comparison does not wrap. `line_i`=0 matches target 64, and a target below 64 never matches any `line_i`.
- R10: `ev_i[2]` is ignored, because the scanline flag comes only from the comparison. A write with `wr_sel_i`=3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_i | input | 6 | Single-cycle event pulses, one per status bit (bit 2 unused) |
| line_i | input | 10 | Visible-line counter, 0 for the first visible line |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 display enables, 1 DMA enables, 2 raster target, 3 none |
| wr_data_i | input | 16 | Register write data |
| rd_stat_i | input | 1 | Status read strobe; clears the flags |
| stat_o | output | 6 | Sticky status flags |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
Every event position is pulsed under all 64 combinations of the two enable registers. This separates a wrong enable-to-flag mapping from a wrong flag position, and a masked flag from a missing one. The raster target is swept against all 1024 line values for a target above 64, for a target below 64 and for exactly 64. This separates an offset or wrap error from a re-trigger on a held match. Reads that coincide with events, writes to the unused select, and enable changes after a flag is latched separate clear priority from stickiness.

// File: rtl/vstat_pkg.sv
package vstat_pkg;
   localparam int NEV = 6;
   typedef enum int unsigned {
      EV_COLL = 0, EV_OVFL = 1, EV_LINE = 2, EV_SATB = 3, EV_VDMA = 4, EV_VBLK = 5
   } ev_idx_e;
   typedef enum logic [1:0] {
      SEL_DISP = 2'd0, SEL_DMA = 2'd1, SEL_RASTER = 2'd2, SEL_NONE = 2'd3
   } wsel_e;
endpackage

// File: rtl/vstat_cfg_regs.sv
module vstat_cfg_regs
   import vstat_pkg::*;
#(
   parameter int DW     = 16,
   parameter int LINE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [1:0]        wr_sel_i,
   input  logic [DW-1:0]     wr_data_i,
   output logic [NEV-1:0]    en_o,
   output logic [LINE_W-1:0] raster_o
);
   generate
      if (DW < LINE_W) begin : g_bad_dw
         $error("vstat_cfg_regs: DW must be at least LINE_W");
      end
      if (DW < 4) begin : g_bad_dw4
         $error("vstat_cfg_regs: DW must be at least 4");
      end
   endgenerate

   logic [3:0]        disp_q;
   logic [1:0]        dma_q;
   logic [LINE_W-1:0] raster_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         disp_q   <= '0;
         dma_q    <= '0;
         raster_q <= '0;
      end else if (wr_en_i) begin
         unique case (wsel_e'(wr_sel_i))
            SEL_DISP:   disp_q   <= wr_data_i[3:0];
            SEL_DMA:    dma_q    <= wr_data_i[1:0];
            SEL_RASTER: raster_q <= wr_data_i[LINE_W-1:0];
            SEL_NONE:   ;
         endcase
      end
   end

   always_comb begin
      en_o          = '0;
      en_o[EV_COLL] = disp_q[0];
      en_o[EV_OVFL] = disp_q[1];
      en_o[EV_LINE] = disp_q[2];
      en_o[EV_VBLK] = disp_q[3];
      en_o[EV_SATB] = dma_q[0];
      en_o[EV_VDMA] = dma_q[1];
   end
   assign raster_o = raster_q;

   p_sel_none_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_sel_i == SEL_NONE) |=> ($stable(en_o) && $stable(raster_o)));
   p_no_write_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i |=> ($stable(en_o) && $stable(raster_o)));
endmodule

// File: rtl/vstat_line_cmp.sv
module vstat_line_cmp #(
   parameter int LINE_W   = 10,
   parameter int LINE_OFS = 64,
   parameter bit EDGE_DET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINE_W-1:0] line_i,
   input  logic [LINE_W-1:0] raster_i,
   output logic              hit_o
);
   localparam int PW = LINE_W + 1;

   generate
      if (LINE_OFS < 0 || LINE_OFS >= (1 << LINE_W)) begin : g_bad_ofs
         $error("vstat_line_cmp: LINE_OFS out of range");
      end
   endgenerate

   logic [PW-1:0] pos;
   logic          match_c;

   assign pos     = {1'b0, line_i} + PW'(LINE_OFS);
   assign match_c = (pos == {1'b0, raster_i});

   generate
      if (EDGE_DET) begin : g_edge
         logic match_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) match_q <= 1'b0;
            else        match_q <= match_c;
         end
         assign hit_o = match_c & ~match_q;

         p_hit_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
            hit_o |=> !hit_o);
      end else begin : g_level
         assign hit_o = match_c;
      end
   endgenerate

   p_low_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (raster_i < LINE_W'(LINE_OFS)) |-> !hit_o);
endmodule

// File: rtl/vstat_flag_bank.sv
module vstat_flag_bank #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic         clr_i,
   output logic [N-1:0] flag_o
);
   generate
      if (N < 1) begin : g_bad_n
         $error("vstat_flag_bank: N must be positive");
      end
   endgenerate

   for (genvar k = 0; k < N; k++) begin : g_flag
      logic f_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        f_q <= 1'b0;
         else if (set_i[k]) f_q <= 1'b1;
         else if (clr_i)    f_q <= 1'b0;
      end
      assign flag_o[k] = f_q;

      p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[k] |=> flag_o[k]);
      p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_o[k] && !clr_i) |=> flag_o[k]);
      p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i && !set_i[k]) |=> !flag_o[k]);
      p_no_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (!flag_o[k] && !set_i[k]) |=> !flag_o[k]);
   end
endmodule

// File: rtl/vstat_irq_ctrl.sv
module vstat_irq_ctrl
   import vstat_pkg::*;
#(
   parameter int DW       = 16,
   parameter int LINE_W   = 10,
   parameter int LINE_OFS = 64,
   parameter bit EDGE_DET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NEV-1:0]    ev_i,
   input  logic [LINE_W-1:0] line_i,
   input  logic              wr_en_i,
   input  logic [1:0]        wr_sel_i,
   input  logic [DW-1:0]     wr_data_i,
   input  logic              rd_stat_i,
   output logic [NEV-1:0]    stat_o,
   output logic              irq_o
);
   logic [NEV-1:0]    en;
   logic [LINE_W-1:0] raster;
   logic              line_hit;
   logic [NEV-1:0]    set_vec;
   logic [NEV-1:0]    flags;

   vstat_cfg_regs #(.DW(DW), .LINE_W(LINE_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
      .wr_data_i(wr_data_i), .en_o(en), .raster_o(raster)
   );

   vstat_line_cmp #(.LINE_W(LINE_W), .LINE_OFS(LINE_OFS), .EDGE_DET(EDGE_DET)) u_cmp (
      .clk(clk), .rst_n(rst_n), .line_i(line_i), .raster_i(raster), .hit_o(line_hit)
   );

   always_comb begin
      set_vec          = ev_i;
      set_vec[EV_LINE] = line_hit;
   end

   vstat_flag_bank #(.N(NEV)) u_flags (
      .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(rd_stat_i), .flag_o(flags)
   );

   assign stat_o = flags;
   assign irq_o  = |(flags & en);

   p_irq_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_o == '0) |-> !irq_o);
   p_irq_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat_i && ev_i == '0 && !line_hit) |=> !irq_o);
   p_ev_line_ign_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_i[EV_LINE] && !line_hit && !stat_o[EV_LINE]) |=> !stat_o[EV_LINE]);
endmodule

// File: tb/vstat_irq_ctrl_tb_top.sv
module vstat_irq_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  ev_i = '0;
   logic [9:0]  line_i = '0;
   logic        wr_en_i = 1'b0;
   logic [1:0]  wr_sel_i = '0;
   logic [15:0] wr_data_i = '0;
   logic        rd_stat_i = 1'b0;
   logic [5:0]  stat_o;
   logic        irq_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   vstat_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .line_i(line_i), .wr_en_i(wr_en_i),
      .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .rd_stat_i(rd_stat_i),
      .stat_o(stat_o), .irq_o(irq_o)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] sel, logic [15:0] d);
      wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
      step();
      wr_en_i = 1'b0;
   endtask

   task automatic pulse(logic [5:0] m);
      ev_i = m;
      step();
      ev_i = '0;
   endtask

   task automatic rd(output logic [5:0] s);
      rd_stat_i = 1'b1;
      s = stat_o;
      step();
      rd_stat_i = 1'b0;
   endtask

   function automatic logic [5:0] en_of(logic [3:0] c, logic [1:0] d);
      return {c[3], d[1], d[0], c[2], c[1], c[0]};
   endfunction

   initial begin
      logic [5:0] s;
      logic [5:0] e;
      step();
      chk("R1 stat", stat_o, 0);
      chk("R1 irq", irq_o, 0);
      rst_n = 1'b1;
      step();
      pulse(6'h01);
      chk("R1 enables zero: irq", irq_o, 0);
      rd(s);

      // R2 R3 R4 R5 R10: every event under every enable combination
      for (int m = 0; m < 64; m++) begin
         wr(2'd0, 16'(m & 15));
         wr(2'd1, 16'(m >> 4));
         e = en_of(4'(m & 15), 2'(m >> 4));
         for (int k = 0; k < 6; k++) begin
            logic [5:0] x;
            x = (k == 2) ? 6'h00 : 6'(1 << k);
            pulse(6'(1 << k));
            chk((k == 2) ? "R10 ev bit2 ignored" : (e[k] ? "R2 stat" : "R3 stat masked"), stat_o, x);
            chk("R4 irq", irq_o, |(x & e));
            rd(s);
            chk("R5 read value", s, x);
            chk("R5 cleared", stat_o, 0);
            chk("R5 irq low", irq_o, 0);
         end
      end

      // R6: event together with read
      wr(2'd0, 16'h0000); wr(2'd1, 16'h0000);
      pulse(6'h02);
      rd_stat_i = 1'b1; ev_i = 6'h20;
      step();
      rd_stat_i = 1'b0; ev_i = '0;
      chk("R6 event kept over read", stat_o, 6'h20);
      rd(s);

      // R8: enable change after latch
      pulse(6'h10);
      chk("R8 irq before enable", irq_o, 0);
      wr(2'd1, 16'h0002);
      chk("R8 irq after enable", irq_o, 1);
      chk("R8 flags unchanged", stat_o, 6'h10);
      repeat (3) step();
      chk("R8 sticky", stat_o, 6'h10);
      wr(2'd1, 16'h0000);
      chk("R8 flags after disable", stat_o, 6'h10);
      chk("R8 irq after disable", irq_o, 0);
      rd(s);

      // R10: unused select has no effect
      wr(2'd3, 16'hFFFF);
      pulse(6'h3B);
      chk("R10 select 3 no enables", irq_o, 0);
      rd(s);

      // R7: raster sweep, target 69 matches only line 5
      wr(2'd0, 16'h0004);
      wr(2'd2, 16'd69);
      step();
      for (int l = 0; l < 1024; l++) begin
         line_i = 10'(l);
         step();
         chk("R7 raster 69 sweep", stat_o[2], (l + 64 == 69));
         chk("R7 irq", irq_o, (l + 64 == 69));
         rd(s);
      end
      line_i = 10'd5;
      step();
      chk("R7 match entry", stat_o[2], 1);
      rd(s);
      repeat (5) step();
      chk("R7 no retrigger on held match", stat_o[2], 0);

      // R9: target below 64 never matches
      wr(2'd2, 16'd10);
      for (int l = 0; l < 1024; l++) begin
         line_i = 10'(l);
         step();
         chk("R9 low target", stat_o[2], 0);
      end
      // R9: line 0 is 64
      line_i = 10'd0;
      step();
      wr(2'd2, 16'd64);
      step();
      chk("R9 line0 equals 64", stat_o[2], 1);
      rd(s);
      chk("R9 read value", s, 6'h04);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule